// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Two-Entry Frame Queue

This block turns an asynchronous serial line into a short queue of received frames. Each frame is a start bit, eight data bits sent least significant bit first, an optional ninth bit, and a stop bit. A shift register assembles the frame that is arriving. Two completed frames wait in a first-in first-out queue, so one frame can be assembled while two others are still waiting to be read.

Each queue entry keeps its data byte, its ninth bit and its framing status together. This way the status shown on the outputs always belongs to the frame at the head of the queue. When the queue is full and another frame completes, the receiver drops that new frame and raises a sticky overrun indication. The indication clears only when the receive enable is dropped and raised again. In 9-bit mode an address filter can keep only the frames whose ninth bit is 1.

The serial line is sampled on an external oversample tick, at sixteen ticks per bit by default. Generating the tick is the job of another block.

Top module: `async_rx_fifo2`

## Requirements
- R1: After reset, `avail` and `overrun` are 0.
- R2: A frame on `rx_line` is received with its data least significant bit first. Once the frame's stop bit has been sampled, `avail` is 1 and `head_data` holds the byte.
- R3: The queue holds two frames in arrival order. Each `rd_pop` pulse moves the head to the next frame.
- R4: When a frame completes while both entries are full, `overrun` becomes 1 and that frame is discarded. The two stored frames can still be read.
- R5: Once `overrun` is set, no further frames enter the queue. `overrun` stays set until `rx_en` is taken low and then high again.
- R6: A frame whose stop bit is sampled low is stored with its framing flag set. `head_ferr` shows the flag of the head frame only.
- R7: With `nine_en` = 1, the bit after the eighth data bit is captured as the ninth bit. `head_ninth` shows the ninth bit of the head frame.
- R8: With both `nine_en` and `addr_en` at 1, a frame whose ninth bit is 0 is dropped and never sets `overrun`.
- R9: While `rx_en` is 0, activity on `rx_line` stores nothing.
- R10: A low pulse that has ended before the middle of the start bit is ignored.
- R11: `avail` is 1 exactly when the queue holds at least one frame. A `rd_pop` on an empty queue has no effect.
- R12: With `nine_en` = 0, stored frames carry a ninth bit of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial input line, idle high |
| os_tick | input | 1 | Oversample tick, OVS ticks per bit |
| rx_en | input | 1 | Receive enable; a low pulse clears overrun |
| nine_en | input | 1 | Nine-bit frame mode |
| addr_en | input | 1 | Keep only frames whose ninth bit is 1 (with nine_en) |
| rd_pop | input | 1 | Removes the head frame |
| avail | output | 1 | Queue is not empty |
| head_data | output | DATA_W | Data of the head frame |
| head_ninth | output | 1 | Ninth bit of the head frame |
| head_ferr | output | 1 | Framing flag of the head frame |
| overrun | output | 1 | Sticky overrun indication |

## Verification
The bench builds the block with its default parameters: eight data bits, sixteen ticks per bit and two queue entries. With only two entries, the third frame reaches overrun after just three transmissions. The bench raises `os_tick` on every third clock rather than on every clock, so the receiver's counters can only advance on ticks. A behavioural queue model predicts the head fields and the overrun flag, including frames that arrive while overrun is set and frames removed by the address filter.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_deframer.sv
module srx_deframer
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              rx,
  input  logic              nine_en,
  output logic              fr_valid,
  output logic [DATA_W-1:0] fr_data,
  output logic              fr_ninth,
  output logic              fr_ferr
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(DATA_W + 1);
  localparam int HALF = OVS / 2;

  rx_state_e         state;
  logic [CW-1:0]     tcnt;
  logic [BW-1:0]     bcnt;
  logic [DATA_W-1:0] shreg;
  logic              ninth_q;
  logic              prev;
  logic              full_bit;

  assign full_bit = (tcnt == CW'(OVS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      tcnt     <= '0;
      bcnt     <= '0;
      shreg    <= '0;
      ninth_q  <= 1'b0;
      prev     <= 1'b1;
      fr_valid <= 1'b0;
      fr_ferr  <= 1'b0;
    end else begin
      fr_valid <= 1'b0;
      if (tick) prev <= rx;
      if (!en) begin
        state <= ST_IDLE;
        tcnt  <= '0;
      end else if (tick) begin
        case (state)
          ST_IDLE: begin
            if (prev && !rx) begin
              state <= ST_START;
              tcnt  <= '0;
            end
          end
          ST_START: begin
            if (tcnt == CW'(HALF - 1)) begin
              tcnt    <= '0;
              bcnt    <= '0;
              ninth_q <= 1'b0;
              state   <= rx ? ST_IDLE : ST_DATA;
            end else begin
              tcnt <= tcnt + CW'(1);
            end
          end
          ST_DATA: begin
            if (full_bit) begin
              tcnt  <= '0;
              shreg <= {rx, shreg[DATA_W-1:1]};
              if (bcnt == BW'(DATA_W - 1)) state <= nine_en ? ST_NINTH : ST_STOP;
              else                         bcnt  <= bcnt + BW'(1);
            end else begin
              tcnt <= tcnt + CW'(1);
            end
          end
          ST_NINTH: begin
            if (full_bit) begin
              tcnt    <= '0;
              ninth_q <= rx;
              state   <= ST_STOP;
            end else begin
              tcnt <= tcnt + CW'(1);
            end
          end
          ST_STOP: begin
            if (full_bit) begin
              tcnt     <= '0;
              fr_valid <= 1'b1;
              fr_ferr  <= !rx;
              state    <= ST_IDLE;
            end else begin
              tcnt <= tcnt + CW'(1);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign fr_data  = shreg;
  assign fr_ninth = ninth_q;

  // R9
  disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (state == ST_IDLE));

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fr_valid |=> !fr_valid);

  // R12
  no_ninth_chk: assert property (@(posedge clk) disable iff (rst)
    (fr_valid && !nine_en && !$past(nine_en)) |-> !fr_ninth);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [LW-1:0] cnt;
  logic          do_push;
  logic          do_pop;

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + LW'(1);
        2'b01:   cnt <= cnt - LW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign level = cnt;

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LW'(DEPTH));

  // R11
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> empty);

  // R3
  push_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !full) |=> (cnt == $past(cnt) + LW'(1)));
endmodule

// File: rtl/async_rx_fifo2.sv
module async_rx_fifo2 #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  input  logic              os_tick,
  input  logic              rx_en,
  input  logic              nine_en,
  input  logic              addr_en,
  input  logic              rd_pop,
  output logic              avail,
  output logic [DATA_W-1:0] head_data,
  output logic              head_ninth,
  output logic              head_ferr,
  output logic              overrun
);
  localparam int EW = DATA_W + 2;
  localparam int LW = $clog2(DEPTH + 1);

  logic              rx_s;
  logic              fr_valid;
  logic [DATA_W-1:0] fr_data;
  logic              fr_ninth;
  logic              fr_ferr;
  logic              drop_filt;
  logic              push;
  logic [EW-1:0]     head;
  logic [LW-1:0]     level;
  logic              full;
  logic              empty;

  srx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .din(rx_line), .dout(rx_s)
  );

  srx_deframer #(.DATA_W(DATA_W), .OVS(OVS)) u_deframer (
    .clk(clk), .rst(rst), .en(rx_en), .tick(os_tick), .rx(rx_s),
    .nine_en(nine_en), .fr_valid(fr_valid), .fr_data(fr_data),
    .fr_ninth(fr_ninth), .fr_ferr(fr_ferr)
  );

  assign drop_filt = nine_en && addr_en && !fr_ninth;
  assign push      = fr_valid && rx_en && !drop_filt && !overrun && !full;

  always_ff @(posedge clk) begin
    if (rst || !rx_en)                       overrun <= 1'b0;
    else if (fr_valid && !drop_filt && full) overrun <= 1'b1;
  end

  srx_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din({fr_ferr, fr_ninth, fr_data}),
    .pop(rd_pop), .dout(head), .level(level), .full(full), .empty(empty)
  );

  assign avail      = !empty;
  assign head_data  = head[DATA_W-1:0];
  assign head_ninth = head[DATA_W];
  assign head_ferr  = head[DATA_W+1];

  // R4
  overrun_on_full_chk: assert property (@(posedge clk) disable iff (rst)
    (fr_valid && rx_en && !drop_filt && full) |=> overrun);

  // R5
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overrun && rx_en) |=> overrun);

  // R5
  overrun_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (overrun && !rd_pop) |=> (level == $past(level)));

  // R8
  filter_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (fr_valid && drop_filt && !rd_pop) |=> ($stable(level) && $stable(overrun)));
endmodule

// File: tb/async_rx_fifo2_bench.sv
module async_rx_fifo2_bench;
  localparam int TDIV   = 3;
  localparam int BITCLK = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b1;
  logic       os_tick;
  logic       rx_en = 1'b0;
  logic       nine_en = 1'b0;
  logic       addr_en = 1'b0;
  logic       rd_pop = 1'b0;
  logic       avail;
  logic [7:0] head_data;
  logic       head_ninth;
  logic       head_ferr;
  logic       overrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int tdiv_cnt = 0;

  logic [9:0] mq[$];
  bit m_ovr = 1'b0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
  assign os_tick = (tdiv_cnt == 0);

  async_rx_fifo2 u_async_rx_fifo2 (
    .clk(clk), .rst(rst), .rx_line(rx_line), .os_tick(os_tick),
    .rx_en(rx_en), .nine_en(nine_en), .addr_en(addr_en), .rd_pop(rd_pop),
    .avail(avail), .head_data(head_data), .head_ninth(head_ninth),
    .head_ferr(head_ferr), .overrun(overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " avail"}, int'(avail), int'(mq.size() > 0));
    chk({tag, " overrun"}, int'(overrun), int'(m_ovr));
    if (mq.size() > 0) begin
      chk({tag, " data"},  int'(head_data),  int'(mq[0][7:0]));
      chk({tag, " ninth"}, int'(head_ninth), int'(mq[0][8]));
      chk({tag, " ferr"},  int'(head_ferr),  int'(mq[0][9]));
    end
  endtask

  task automatic wait_bit();
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic model_frame(input logic [7:0] d, input logic n9, input logic ferr);
    if (!rx_en) return;
    if (nine_en && addr_en && !n9) return;
    if (m_ovr || mq.size() == 2) m_ovr = 1'b1;
    else mq.push_back({ferr, n9, d});
  endtask

  task automatic send_frame(input logic [7:0] d, input logic n9, input logic stopv);
    rx_line = 1'b0;
    wait_bit();
    for (int i = 0; i < 8; i++) begin
      rx_line = d[i];
      wait_bit();
    end
    if (nine_en) begin
      rx_line = n9;
      wait_bit();
    end
    rx_line = stopv;
    wait_bit();
    rx_line = 1'b1;
    wait_bit();
    wait_bit();
    model_frame(d, nine_en ? n9 : 1'b0, !stopv);
  endtask

  task automatic pop_one();
    @(negedge clk) rd_pop = 1'b1;
    @(negedge clk) rd_pop = 1'b0;
    if (mq.size() > 0) void'(mq.pop_front());
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare_all("R1 reset");
    rx_en = 1'b1;
    wait_bit();

    send_frame(8'hA5, 1'b0, 1'b1);
    compare_all("R2 R12 first frame");
    send_frame(8'h3C, 1'b0, 1'b1);
    compare_all("R3 two queued");
    pop_one();
    compare_all("R3 second head");
    pop_one();
    compare_all("R11 drained");
    pop_one();
    compare_all("R11 pop on empty");

    send_frame(8'h11, 1'b0, 1'b0);
    send_frame(8'h22, 1'b0, 1'b1);
    compare_all("R6 bad stop at head");
    pop_one();
    compare_all("R6 flag follows head");
    pop_one();

    send_frame(8'h01, 1'b0, 1'b1);
    send_frame(8'h02, 1'b0, 1'b1);
    send_frame(8'h03, 1'b0, 1'b1);
    compare_all("R4 third frame overrun");
    pop_one();
    compare_all("R4 stored frame kept");
    send_frame(8'h04, 1'b0, 1'b1);
    compare_all("R5 blocked while set");
    pop_one();
    compare_all("R5 still sticky");
    @(negedge clk) rx_en = 1'b0;
    m_ovr = 1'b0;
    repeat (4) @(negedge clk);
    rx_en = 1'b1;
    @(negedge clk);
    compare_all("R5 cleared by toggle");
    send_frame(8'h5A, 1'b0, 1'b1);
    compare_all("R5 receives again");
    pop_one();

    rx_en = 1'b0;
    send_frame(8'h55, 1'b0, 1'b1);
    compare_all("R9 disabled");
    rx_en = 1'b1;
    wait_bit();

    rx_line = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    rx_line = 1'b1;
    wait_bit();
    wait_bit();
    compare_all("R10 glitch ignored");

    nine_en = 1'b1;
    send_frame(8'h80, 1'b1, 1'b1);
    send_frame(8'h7F, 1'b0, 1'b1);
    compare_all("R7 ninth one");
    pop_one();
    compare_all("R7 ninth zero");
    pop_one();

    addr_en = 1'b1;
    send_frame(8'h12, 1'b0, 1'b1);
    compare_all("R8 plain frame dropped");
    send_frame(8'h34, 1'b1, 1'b1);
    compare_all("R8 address frame kept");
    send_frame(8'h56, 1'b0, 1'b1);
    send_frame(8'h78, 1'b0, 1'b1);
    send_frame(8'h9A, 1'b1, 1'b1);
    compare_all("R8 full after address frames");
    send_frame(8'hBC, 1'b0, 1'b1);
    compare_all("R8 filtered while full no overrun");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule